// File: doc/BRIEF.md
# Mode Control Register Bank with Staged Updates

This block holds the single mode byte of a multichannel audio converter's control port. A parallel strobe bus replaces the serial front end. A write to the mode address always lands in a staged copy of the byte. The converter is driven from a separate active copy. While the hold bit is set, the staged copy may change but the active copy keeps its slow-acting fields. Clearing the hold bit moves every pending change into the active copy on one clock edge, so several settings can switch together.

The active copy drives four kinds of output. The first is the control-port-enable flag. The second is a power-down flag. The third is one hold-in-reset line per converter channel pair. The fourth is a core clock, which is either the master clock itself or the master clock divided by two through a toggle flop. Reads go through a registered port and return the staged copy. They are allowed only when the interface is in its read-capable (I2C-style) mode.

Top module: `mode_ctl_bank`

## Requirements
- R1: After reset, the staged and active byte is 0x01: `pdn` is 1, `cp_en` is 0, all `pair_hold` bits are 0, and the core clock is undivided.
- R2: A write to address 0x01 with bit 6 (hold) at 0 updates every output on the same clock edge that accepts the write.
- R3: While the active hold bit (bit 6) is 1, a write to 0x01 changes only the staged byte. The clock-divide bit (5), the pair-disable bits (3..1) and power-down (bit 0) stay active at their old values.
- R4: A write that clears bit 6 applies the whole written byte to the active copy on the edge that accepts it.
- R5: Bit 7 (control-port enable) and bit 6 take effect on the accepting edge even while the hold bit is set.
- R6: Bit 4 is reserved. It is stored as 0 whatever is written, and it reads back as 0.
- R7: A write to any address other than 0x01 leaves the byte and all outputs unchanged.
- R8: With `rd_allow` at 1, a read of 0x01 returns the staged byte on `rdata` one cycle after `rd_en`. With `rd_allow` at 0, or on any cycle that is not the cycle after such a read, `rdata` is 0.
- R9: With active bit 5 at 0, `core_clk` follows `clk`. With bit 5 at 1, `core_clk` changes level once on every rising edge of `clk`, which halves its frequency.
- R10: Active bit 1 drives `pair_hold[0]`, bit 2 drives `pair_hold[1]` and bit 3 drives `pair_hold[2]`. A bit at 1 holds that pair in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_allow | input | 1 | 1 when the interface is in its read-capable mode |
| rdata | output | 8 | Registered read data |
| cp_en | output | 1 | Control port owns the device |
| pdn | output | 1 | Power-down |
| pair_hold | output | 3 | Per-pair hold-in-reset |
| core_clk | output | 1 | Master clock, optionally divided by two |

## Verification
The bench sets the hold bit and then writes new divide, pair and power-down values. A design that leaked these writes would change `pair_hold` or `pdn` early. The bench then flips the control-port-enable bit while the hold is set. A design that gated this bit with the hold would leave `cp_en` stale, and could leave the hold impossible to release. The release write is checked on the exact cycle it is accepted, so a one-cycle-late transfer is caught. Reads check that the reserved bit reads back as 0, that a blocked read returns zero, and that a write to a foreign address changes nothing. The pair outputs are checked one pair at a time, so a reversed bit order is caught.

// File: rtl/mode_ctl_pkg.sv
// Shared constants for the mode control bank: address, reset byte and the
// bit positions that the outputs decode.
package mode_ctl_pkg;
    localparam int          DW       = 8;
    localparam logic [7:0]  REG_ADDR = 8'h01;
    localparam logic [7:0]  RST_VAL  = 8'h01;
    localparam int          CPEN_B   = 7;
    localparam int          FRZ_B    = 6;
    localparam int          DIV_B    = 5;
    localparam int          RSV_B    = 4;
    localparam int          PAIR_LSB = 1;
    localparam int          NPAIR    = 3;
    localparam int          PDN_B    = 0;
endpackage

// File: rtl/mode_ctl_regs.sv
// Staged and active copies of the mode byte.
// Assumes: full-byte writes. The hold bit and control-port enable are never
// held back. Every other field moves to the active copy only while the
// resulting hold bit is 0.
module mode_ctl_regs
    import mode_ctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] staged,
    output logic [DW-1:0] active
);
    localparam logic [AW-1:0] MY_ADDR = AW'(REG_ADDR);

    logic          hit;
    logic [DW-1:0] stg_nx;
    logic [DW-1:0] act_nx;

    // Decode a write to the mode address and mask the reserved bit.
    always_comb begin
        hit    = wr_en && (addr == MY_ADDR);
        stg_nx = staged;
        if (hit) begin
            stg_nx        = wdata;
            stg_nx[RSV_B] = 1'b0;
        end
    end

    // Build the next active byte: bits 7 and 6 always follow, the rest only when not held.
    always_comb begin
        if (stg_nx[FRZ_B]) begin
            act_nx             = active;
            act_nx[CPEN_B]     = stg_nx[CPEN_B];
            act_nx[FRZ_B]      = stg_nx[FRZ_B];
        end else begin
            act_nx = stg_nx;
        end
    end

    // Register both copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= RST_VAL;
            active <= RST_VAL;
        end else begin
            staged <= stg_nx;
            active <= act_nx;
        end
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active[FRZ_B] && $past(active[FRZ_B])) |-> $stable(active[DIV_B:0])); // R3
    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active[FRZ_B]) |-> (active == staged)); // R4
    AST_CPEN_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MY_ADDR) |=> (active[CPEN_B] == $past(wdata[CPEN_B]))); // R5
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !staged[RSV_B]); // R6
    AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == MY_ADDR)) |=> $stable(staged)); // R7
endmodule

// File: rtl/mode_ctl_rdport.sv
// Registered read port. It returns the staged byte one cycle after a
// permitted read of the mode address, and zero otherwise.
// Assumes: rd_allow reflects the interface mode and is steady around a read.
module mode_ctl_rdport
    import mode_ctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_allow,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] staged,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] MY_ADDR = AW'(REG_ADDR);

    // Capture read data for one cycle and return zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en && rd_allow && addr == MY_ADDR)
            rdata <= staged;
        else
            rdata <= '0;
    end

    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_allow) |=> (rdata == '0)); // R8
endmodule

// File: rtl/mode_ctl_clkdiv.sv
// Optional divide-by-two of the master clock. A toggle flop runs while the
// enable is set, and a bypass mux picks the toggle output or the raw clock.
// Assumes: the enable comes from a register clocked by clk.
module mode_ctl_clkdiv (
    input  logic clk,
    input  logic rst_n,
    input  logic div_en,
    output logic core_clk
);
    logic tog;

    // Toggle on every edge while enabled, and park at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (div_en)
            tog <= ~tog;
        else
            tog <= 1'b0;
    end

    // Bypass mux between the divided clock and the raw clock.
    always_comb core_clk = div_en ? tog : clk;

    AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_en) |-> (tog != $past(tog))); // R9
endmodule

// File: rtl/mode_ctl_pairgate.sv
// Maps each active pair-disable bit to that pair's hold-in-reset line.
// Assumes: the disable bits come from the active copy, lowest pair first.
module mode_ctl_pairgate #(
    parameter int NP = 3
) (
    input  logic [NP-1:0] dis,
    output logic [NP-1:0] hold
);
    for (genvar i = 0; i < NP; i++) begin : g_pair
        // One hold line per pair.
        always_comb hold[i] = dis[i];
    end
endmodule

// File: rtl/mode_ctl_bank.sv
// Top of the mode control bank. It ties the staged/active register pair, the
// read port, the clock divider and the per-pair reset gating together.
// Assumes: clk is the master clock and rst_n is synchronous to it.
module mode_ctl_bank
    import mode_ctl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    rd_allow,
    output logic [DW-1:0]           rdata,
    output logic                    cp_en,
    output logic                    pdn,
    output logic [NPAIR-1:0]        pair_hold,
    output logic                    core_clk
);
    logic [DW-1:0] staged;
    logic [DW-1:0] active;

    mode_ctl_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .staged(staged), .active(active)
    );

    mode_ctl_rdport #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_allow(rd_allow),
        .addr(addr), .staged(staged), .rdata(rdata)
    );

    mode_ctl_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .div_en(active[DIV_B]), .core_clk(core_clk)
    );

    mode_ctl_pairgate #(.NP(NPAIR)) u_pairs (
        .dis(active[PAIR_LSB +: NPAIR]), .hold(pair_hold)
    );

    // Drive the flag outputs from the active copy.
    always_comb begin
        cp_en = active[CPEN_B];
        pdn   = active[PDN_B];
    end

    AST_PDN_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (pdn && !cp_en && pair_hold == '0)); // R1
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(REG_ADDR) && !wdata[FRZ_B])
        |=> (pdn == $past(wdata[PDN_B]))); // R2
endmodule

// File: tb/mode_ctl_bank_bench.sv
// Scoreboard bench for mode_ctl_bank.
module mode_ctl_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rd_allow = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       cp_en, pdn, core_clk;
    logic [2:0] pair_hold;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit rd_q = 1'b0;

    typedef struct { logic [7:0] val; string tag; } rd_item_t;
    rd_item_t exp_q[$];

    always #2 clk = ~clk;

    mode_ctl_bank u_mode_ctl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_allow(rd_allow), .rdata(rdata),
        .cp_en(cp_en), .pdn(pdn), .pair_hold(pair_hold), .core_clk(core_clk)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: one cycle after an accepted read strobe, pop and compare.
    always @(posedge clk) rd_q <= rd_en;
    always @(negedge clk) begin
        if (rd_q) begin
            rd_item_t it;
            if (exp_q.size() == 0) begin
                chk("R8 scoreboard empty", 8'h00, 8'hFF);
            end else begin
                it = exp_q.pop_front();
                chk(it.tag, rdata, it.val);
            end
        end
    end

    // Drivers change inputs on the falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back('{val: exp, tag: tag});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic outs(input string tag, input logic c, input logic p, input logic [2:0] h);
        chk({tag, " cp_en"}, {7'd0, cp_en}, {7'd0, c});
        chk({tag, " pdn"},   {7'd0, pdn},   {7'd0, p});
        chk({tag, " pair_hold"}, {5'd0, pair_hold}, {5'd0, h});
    endtask

    task automatic clk_mode(input bit divided, input string tag);
        logic [7:0] prev;
        logic [7:0] cur;
        @(posedge clk); #1 prev = {7'd0, core_clk};
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 cur = {7'd0, core_clk};
            if (divided) chk(tag, cur, ~prev & 8'h01);
            else         chk(tag, cur, 8'h01);
            prev = cur;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R1 reset", 1'b0, 1'b1, 3'b000);
        rd(8'h01, 8'h01, "R1 reset readback");
        clk_mode(1'b0, "R1 R9 undivided after reset");

        // Open write: pairs 1..3 disabled, power up.
        wr(8'h01, 8'h0E);
        outs("R2 open write", 1'b0, 1'b0, 3'b111);
        rd(8'h01, 8'h0E, "R2 readback");

        // Set hold together with new divide and power-down values.
        wr(8'h01, 8'h61);
        outs("R3 held fields", 1'b0, 1'b0, 3'b111);
        clk_mode(1'b0, "R3 divide held");
        rd(8'h01, 8'h61, "R8 staged readback while held");

        // Control-port enable while held.
        wr(8'h01, 8'hC1);
        outs("R5 cp_en immediate", 1'b1, 1'b0, 3'b111);

        // Release with reserved bit set in the written byte.
        wr(8'h01, 8'h35);
        outs("R4 release", 1'b0, 1'b1, 3'b010);
        rd(8'h01, 8'h25, "R6 reserved reads zero");
        clk_mode(1'b1, "R9 divided");

        // A foreign address is ignored.
        wr(8'h02, 8'hFF);
        outs("R7 foreign write", 1'b0, 1'b1, 3'b010);
        rd(8'h01, 8'h25, "R7 byte unchanged");
        rd(8'h02, 8'h00, "R8 foreign read zero");

        // A blocked read returns zero.
        rd_allow = 1'b0;
        rd(8'h01, 8'h00, "R8 read blocked");
        rd_allow = 1'b1;

        // Pair order.
        wr(8'h01, 8'h02);
        outs("R10 pair1", 1'b0, 1'b0, 3'b001);
        wr(8'h01, 8'h08);
        outs("R10 pair3", 1'b0, 1'b0, 3'b100);
        clk_mode(1'b0, "R9 divide off");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule